// File: doc/BRIEF.md
# Saturating Up-Down Integrator Deglitcher

This block cleans up a single noisy digital level that has already been brought into the local clock domain. It keeps a bounded up/down counter that works as a digital integrator. On every clock the counter takes one step toward the sampled level: up when the sample is 1 and down when it is 0. It stops at zero and at a configurable top value and never wraps past either one.

The filtered output has hysteresis. A low output goes high only when the counter arrives at the top value, and a high output goes low only when the counter arrives at zero. A single sample of the wrong polarity in the middle of a transition only costs extra clocks. It does not restart the transition. A larger top value rejects longer bursts of noise but adds delay, because a clean edge takes exactly the top value in clocks to pass through. The counter value is brought out as well, so a user can watch how close the filter is to switching.

Top module: `level_integrator`

## Requirements
- R1: On a clock edge where the sample is 1 and the counter is below MAX_COUNT, the counter increases by exactly one.
- R2: On a clock edge where the sample is 0 and the counter is above zero, the counter decreases by exactly one.
- R3: The counter saturates. A 1 sample at MAX_COUNT leaves it at MAX_COUNT, a 0 sample at zero leaves it at zero, and it never goes above MAX_COUNT.
- R4: While the filtered output is 0, it becomes 1 on the same edge on which the counter reaches MAX_COUNT, and at no other time.
- R5: While the filtered output is 1, it becomes 0 on the same edge on which the counter reaches zero, and at no other time.
- R6: An isolated opposite sample during a transition delays the output change by two clocks and does not restart the count. With MAX_COUNT=3, starting from reset, the samples 1,1,0,1,1 keep the output at 0 through the fourth sample and raise it on the fifth.
- R7: While reset (active low) is asserted, the counter is 0 and the filtered output is 0.
- R8: Starting from a settled state, a constant run of the opposite level switches the output after exactly MAX_COUNT samples. This holds for both the rising and the falling direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | 1 | Synchronized raw level, sampled every clock |
| filtOut | output | 1 | Registered, filtered level |
| countOut | output | $clog2(MAX_COUNT+1) | Current integrator value, 0 to MAX_COUNT |

## Verification
The bound checker watches every cycle for the single-step movement of the counter, for saturation at both ends and for the upper bound. It also checks that every output edge lines up with the counter at the matching limit, and that the output is never low while the counter sits at the top, nor high while it sits at zero. What the per-cycle properties cannot show is whole-sequence behaviour. That covers the exact switching latency of a clean run, the delay-without-restart effect of one stray sample, and the reset values. The bench covers these with an exhaustive sweep of every 8-sample pattern from reset and with directed runs compared against an arithmetic model.

// File: rtl/deglitch_pkg.sv
package deglitch_pkg;

  // Step commands issued by the control to the counter datapath.
  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } stepCmd_t;

  // Position flags reported by the datapath to the control.
  typedef struct packed {
    logic atTop;
    logic atBottom;
    logic nearTop;
    logic nearBottom;
  } cntFlags_t;

endpackage

// File: rtl/integrator_datapath.sv
module integrator_datapath
  import deglitch_pkg::*;
#(
  parameter int MAX_COUNT = 7,
  localparam int CNT_W = $clog2(MAX_COUNT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepCmd_t         cmd,
  output cntFlags_t        flags,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] TOP_VAL  = CNT_W'(MAX_COUNT);
  localparam logic [CNT_W-1:0] NEAR_TOP = CNT_W'(MAX_COUNT - 1);
  localparam logic [CNT_W-1:0] ONE_VAL  = CNT_W'(1);

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] countD;

  always_comb begin
    countD = countQ;
    if (cmd.stepUp)
      countD = countQ + ONE_VAL;
    else if (cmd.stepDown)
      countD = countQ - ONE_VAL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      countQ <= '0;
    else
      countQ <= countD;
  end

  always_comb begin
    flags.atTop      = (countQ == TOP_VAL);
    flags.atBottom   = (countQ == '0);
    flags.nearTop    = (countQ == NEAR_TOP);
    flags.nearBottom = (countQ == ONE_VAL);
  end

  assign count = countQ;

endmodule

// File: rtl/integrator_control.sv
module integrator_control
  import deglitch_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleIn,
  input  cntFlags_t flags,
  output stepCmd_t  cmd,
  output logic      level
);

  logic levelQ;
  logic riseNow;
  logic fallNow;

  always_comb begin
    cmd.stepUp   = sampleIn  & ~flags.atTop;
    cmd.stepDown = ~sampleIn & ~flags.atBottom;
    // Output flips on the edge whose step lands on the far limit.
    riseNow = ~levelQ & cmd.stepUp   & flags.nearTop;
    fallNow =  levelQ & cmd.stepDown & flags.nearBottom;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      levelQ <= 1'b0;
    else if (riseNow)
      levelQ <= 1'b1;
    else if (fallNow)
      levelQ <= 1'b0;
  end

  assign level = levelQ;

endmodule

// File: rtl/level_integrator.sv
module level_integrator
  import deglitch_pkg::*;
#(
  parameter int MAX_COUNT = 7,
  localparam int CNT_W = $clog2(MAX_COUNT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleIn,
  output logic             filtOut,
  output logic [CNT_W-1:0] countOut
);

  stepCmd_t  cmd;
  cntFlags_t flags;

  integrator_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sampleIn (sampleIn),
    .flags    (flags),
    .cmd      (cmd),
    .level    (filtOut)
  );

  integrator_datapath #(.MAX_COUNT(MAX_COUNT)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .cmd   (cmd),
    .flags (flags),
    .count (countOut)
  );

endmodule

// File: rtl/level_integrator_checker.sv
module level_integrator_checker #(
  parameter int MAX_COUNT = 7,
  localparam int CNT_W = $clog2(MAX_COUNT + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleIn,
  input logic             filtOut,
  input logic [CNT_W-1:0] countOut
);

  localparam logic [CNT_W-1:0] TOP_VAL = CNT_W'(MAX_COUNT);
  localparam logic [CNT_W-1:0] ONE_VAL = CNT_W'(1);

  assert_step_up_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sampleIn && countOut < TOP_VAL) |=> countOut == $past(countOut) + ONE_VAL);

  assert_step_down_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleIn && countOut != '0) |=> countOut == $past(countOut) - ONE_VAL);

  assert_hold_top_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sampleIn && countOut == TOP_VAL) |=> countOut == TOP_VAL);

  assert_hold_bottom_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleIn && countOut == '0) |=> countOut == '0);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    countOut <= TOP_VAL);

  assert_rise_at_top_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(filtOut) |-> countOut == TOP_VAL);

  assert_low_not_at_top_R4: assert property (@(posedge clk) disable iff (!rstN)
    !filtOut |-> countOut != TOP_VAL);

  assert_fall_at_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(filtOut) |-> countOut == '0);

  assert_high_not_at_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    filtOut |-> countOut != '0);

endmodule

bind level_integrator level_integrator_checker #(.MAX_COUNT(MAX_COUNT)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sampleIn (sampleIn),
  .filtOut  (filtOut),
  .countOut (countOut)
);

// File: tb/level_integrator_test.sv
module level_integrator_test;

  localparam int TB_MAX = 3;
  localparam int TB_W   = $clog2(TB_MAX + 1);
  localparam int SEQ_LEN = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleIn = 1'b0;
  logic filtOut;
  logic [TB_W-1:0] countOut;

  int testsRun = 0;
  int testsFailed = 0;
  int mCnt = 0;
  int mOut = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  level_integrator #(.MAX_COUNT(TB_MAX)) uut (
    .clk      (clk),
    .rstN     (rstN),
    .sampleIn (sampleIn),
    .filtOut  (filtOut),
    .countOut (countOut)
  );

  task automatic check(input int act, input int exp, input string tag);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    sampleIn = 1'b0;
    @(negedge clk);
    mCnt = 0;
    mOut = 0;
    check(int'(countOut), 0, "R7 count in reset");
    check(int'(filtOut), 0, "R7 output in reset");
    rstN = 1'b1;
  endtask

  task automatic applySample(input logic b);
    string cTag;
    string oTag;
    @(negedge clk);
    sampleIn = b;
    if (b) cTag = (mCnt == TB_MAX) ? "R3 hold top" : "R1 step up";
    else   cTag = (mCnt == 0) ? "R3 hold bottom" : "R2 step down";
    oTag = (mOut == 0) ? "R4 output low side" : "R5 output high side";
    if (b && mCnt < TB_MAX) mCnt++;
    else if (!b && mCnt > 0) mCnt--;
    if (mOut == 0 && mCnt == TB_MAX) mOut = 1;
    else if (mOut == 1 && mCnt == 0) mOut = 0;
    @(posedge clk);
    #1;
    check(int'(countOut), mCnt, cTag);
    check(int'(filtOut), mOut, oTag);
  endtask

  initial begin
    int n;
    // R7: reset state
    doReset();

    // Exhaustive sweep of every 8-sample pattern from reset (R1..R5)
    for (int seq = 0; seq < (1 << SEQ_LEN); seq++) begin
      doReset();
      for (int i = 0; i < SEQ_LEN; i++) applySample(seq[i]);
    end

    // R6: one stray 0 mid-rise delays but does not restart
    doReset();
    applySample(1'b1);
    applySample(1'b1);
    applySample(1'b0);
    applySample(1'b1);
    check(int'(filtOut), 0, "R6 still low after fourth sample");
    applySample(1'b1);
    check(int'(filtOut), 1, "R6 high after fifth sample");

    // R8: clean rise latency
    doReset();
    n = 0;
    while (filtOut == 1'b0 && n < 20) begin
      applySample(1'b1);
      n++;
    end
    check(n, TB_MAX, "R8 rise latency");
    for (int i = 0; i < 4; i++) applySample(1'b1);
    // R8: clean fall latency from settled high
    n = 0;
    while (filtOut == 1'b1 && n < 20) begin
      applySample(1'b0);
      n++;
    end
    check(n, TB_MAX, "R8 fall latency");
    check(int'(countOut), 0, "R3 count at bottom after fall");

    // Long alternating pattern with a few runs (R1..R5)
    for (int i = 0; i < 200; i++) applySample(((i * 7) % 5) < 2);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule